// File: doc/BRIEF.md
# Guarded Byte-Array Write Controller

This block sits on a CPU register bus and manages a small byte-wide nonvolatile data array. Here the array is modelled as a register array. Software reaches it through four registers: a byte pointer, a byte buffer, a control/status register and a write-only key register. A read copies the addressed byte into the buffer at once.

A write is guarded against runaway code. Three things must line up before a write starts. Write permission must already be granted in the control register. Two key bytes must arrive at the key register in order. The start bit must then be set within a short window. A write that starts runs for a long programming time, set as a parameter in clock cycles. During that time the start bit reads as 1. At the end the byte is committed, a sticky completion flag is raised and, if enabled, an interrupt request is asserted.

The pointer and byte are captured when the write starts. Software may go on using the registers while the write runs, and nothing it does then reaches the byte being programmed.

Top module: `nvm_write_ctrl`

## Requirements
- R1: After reset, the pointer, buffer, control and key registers all read 0x00 and `irq` is low.
- R2: Writing the control register (offset 2) with bit 0 set while no write is running loads the array byte at the pointer (offset 0) into the buffer (offset 1). The loaded byte reads back in the next cycle. Bit 0 always reads 0.
- R3: A write starts when all of the following hold, in this order: the write-permission bit (control bit 2) is 1, then 0x55 is written to the key register (offset 3), then 0xAA, then the control register is written with bit 1 set. The buffer byte is then stored at the pointer address.
- R4: From the cycle after a write starts, control bit 1 reads 1 for exactly PROG_CYCLES cycles and then returns to 0 by itself.
- R5: A control write with bit 1 set that does not follow a complete key sequence starts nothing. Bit 1 reads 0 in the next cycle and the array is left unchanged.
- R6: Any key-register write other than the expected next key returns the sequence to its start, so a following start request is ignored.
- R7: The start write must land no more than UNLOCK_WINDOW clock edges after the edge that took 0x55. A start request that lands later is ignored.
- R8: With control bit 2 at 0, a complete key sequence followed by a start request writes nothing.
- R9: On completion, control bit 3 (the done flag) is set. It stays set until software writes the control register with bit 3 at 0. Writing bit 3 as 1 never sets it. `irq` is high exactly when bit 3 and bit 4 (the interrupt enable) are both 1.
- R10: While a write runs, writes to the pointer or buffer do not change the byte programmed or its address. Read requests are ignored and leave the buffer unchanged.
- R11: The key register always reads 0x00. Control bits 2 and 4 read back as software last wrote them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 2 | Register offset: 0 pointer, 1 buffer, 2 control, 3 key |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the register at `bus_reg` |
| irq | output | 1 | Write-complete interrupt request |

## Verification
The bench probes the edges of the unlock window: a start landing on the last allowed edge must begin a write, and one landing a cycle later must not. A design with an off-by-one counter would accept the late start or reject the timely one. Wrong second keys, a repeated first key and a cleared permission bit are each sent ahead of a start request; a design that fails any of these would corrupt a byte without authorization. Pointer and buffer writes, and a read request, are issued in the middle of a write; a design without captured copies would program the wrong address or data, and one that ignores the running-write guard would overwrite the buffer. The busy span is timed to the exact cycle. The done flag is checked for its write-zero-to-clear rule and for how it gates `irq`.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    REG_PTR  = 2'd0,
    REG_BUF  = 2'd1,
    REG_CTRL = 2'd2,
    REG_KEY  = 2'd3
  } reg_sel_e;

  localparam int CB_RD   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_WREN = 2;
  localparam int CB_DONE = 3;
  localparam int CB_IE   = 4;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_GOT1  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_st_e;
endpackage

// File: rtl/nvm_rst_sync.sv
module nvm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n = s2_q;
endmodule

// File: rtl/nvm_unlock.sv
module nvm_unlock
  import nvm_pkg::*;
#(
  parameter int WINDOW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_val,
  input  logic              ctrl_wr,
  output logic              armed
);
  localparam int CW = $clog2(WINDOW + 1);

  unlock_st_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    case (st_q)
      UL_IDLE: begin
        if (key_wr && key_val == KEY_FIRST) begin
          st_n  = UL_GOT1;
          cnt_n = CW'(WINDOW);
        end
      end
      UL_GOT1: begin
        cnt_n = cnt_q - 1'b1;
        if (cnt_q == CW'(1))
          st_n = UL_IDLE;
        else if (key_wr)
          st_n = (key_val == KEY_SECOND) ? UL_ARMED : UL_IDLE;
      end
      UL_ARMED: begin
        cnt_n = cnt_q - 1'b1;
        if (key_wr || ctrl_wr || cnt_q == CW'(1))
          st_n = UL_IDLE;
      end
      default: st_n = UL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= UL_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign armed = (st_q == UL_ARMED);
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int PROG_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int PW = $clog2(PROG_CYCLES + 1);

  logic [PW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n;
  logic          cnt_en;

  assign done   = busy_q && (cnt_q == '0);
  assign cnt_en = start || busy_q;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = PW'(PROG_CYCLES - 1);
    end else if (done) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int PROG_CYCLES   = 1250000,
  parameter int UNLOCK_WINDOW = 8
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [1:0] bus_reg,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic rst_n;
  logic armed, busy, done, start, rd_req;
  logic ptr_wr, buf_wr, ctrl_wr, key_wr;

  logic [ADDR_W-1:0] ptr_q, ptr_n, lat_addr_q, lat_addr_n;
  logic [DATA_W-1:0] buf_q, buf_n, lat_data_q, lat_data_n;
  logic [DATA_W-1:0] arr_rdata;
  logic              wr_en_q, wr_en_n, ie_q, ie_n, flag_q, flag_n;

  nvm_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_n));

  assign ptr_wr  = bus_sel && bus_we && (reg_sel_e'(bus_reg) == REG_PTR);
  assign buf_wr  = bus_sel && bus_we && (reg_sel_e'(bus_reg) == REG_BUF);
  assign ctrl_wr = bus_sel && bus_we && (reg_sel_e'(bus_reg) == REG_CTRL);
  assign key_wr  = bus_sel && bus_we && (reg_sel_e'(bus_reg) == REG_KEY);

  nvm_unlock #(.WINDOW(UNLOCK_WINDOW)) u_unlock (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_val(bus_wdata),
    .ctrl_wr(ctrl_wr), .armed(armed)
  );

  assign start  = ctrl_wr && bus_wdata[CB_WR] && armed && wr_en_q && !busy;
  assign rd_req = ctrl_wr && bus_wdata[CB_RD] && !busy;

  nvm_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  nvm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(done), .waddr(lat_addr_q), .wdata(lat_data_q),
    .raddr(ptr_q), .rdata(arr_rdata)
  );

  always_comb begin
    ptr_n      = ptr_wr ? bus_wdata[ADDR_W-1:0] : ptr_q;
    buf_n      = buf_q;
    if (buf_wr)      buf_n = bus_wdata;
    else if (rd_req) buf_n = arr_rdata;
    wr_en_n    = ctrl_wr ? bus_wdata[CB_WREN] : wr_en_q;
    ie_n       = ctrl_wr ? bus_wdata[CB_IE]   : ie_q;
    flag_n     = done || (flag_q && !(ctrl_wr && !bus_wdata[CB_DONE]));
    lat_addr_n = start ? ptr_q : lat_addr_q;
    lat_data_n = start ? buf_q : lat_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      buf_q      <= '0;
      wr_en_q    <= 1'b0;
      ie_q       <= 1'b0;
      flag_q     <= 1'b0;
      lat_addr_q <= '0;
      lat_data_q <= '0;
    end else begin
      ptr_q   <= ptr_n;
      buf_q   <= buf_n;
      wr_en_q <= wr_en_n;
      ie_q    <= ie_n;
      flag_q  <= flag_n;
      if (start) begin
        lat_addr_q <= lat_addr_n;
        lat_data_q <= lat_data_n;
      end
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      logic [DATA_W-1:0] ptr_rd;
      assign ptr_rd = {{PAD_W{1'b0}}, ptr_q};
      always_comb begin
        case (reg_sel_e'(bus_reg))
          REG_PTR:  bus_rdata = ptr_rd;
          REG_BUF:  bus_rdata = buf_q;
          REG_CTRL: bus_rdata = {3'b000, ie_q, flag_q, wr_en_q, busy, 1'b0};
          default:  bus_rdata = '0;
        endcase
      end
    end else begin : g_nopad
      always_comb begin
        case (reg_sel_e'(bus_reg))
          REG_PTR:  bus_rdata = ptr_q[DATA_W-1:0];
          REG_BUF:  bus_rdata = buf_q;
          REG_CTRL: bus_rdata = {3'b000, ie_q, flag_q, wr_en_q, busy, 1'b0};
          default:  bus_rdata = '0;
        endcase
      end
    end
  endgenerate

  assign irq = flag_q && ie_q;
endmodule

// File: rtl/nvm_write_ctrl_chk.sv
module nvm_write_ctrl_chk #(
  parameter int ADDR_W      = 8,
  parameter int PROG_CYCLES = 1250000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_reg,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              irq,
  input logic              busy,
  input logic              armed,
  input logic              wr_en_q,
  input logic              flag_q,
  input logic [ADDR_W-1:0] lat_addr_q,
  input logic [7:0]        lat_data_q
);
  logic [31:0] busy_cnt_q;
  logic        ctrl_w;

  assign ctrl_w = bus_sel && bus_we && (bus_reg == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt_q <= '0;
    else if (busy) busy_cnt_q <= busy_cnt_q + 1;
    else           busy_cnt_q <= '0;
  end

  a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt_q == 32'(PROG_CYCLES));

  a_r3_start_after_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed) && $past(ctrl_w) && $past(bus_wdata[1]));

  a_r8_start_needs_wren: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en_q));

  a_r9_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> flag_q);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(ctrl_w && !bus_wdata[3])) |=> flag_q);

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);

  a_r10_copies_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(lat_addr_q) && $stable(lat_data_q));

  a_r11_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reg == 2'd3) |-> bus_rdata == 8'h00);
endmodule

bind nvm_write_ctrl nvm_write_ctrl_chk #(
  .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .busy(busy), .armed(armed), .wr_en_q(wr_en_q),
  .flag_q(flag_q), .lat_addr_q(lat_addr_q), .lat_data_q(lat_data_q)
);

// File: tb/nvm_write_ctrl_test.sv
module nvm_write_ctrl_test;
  localparam int P   = 20;
  localparam int WIN = 8;
  localparam logic [15:0] VEC [4] = '{16'h0312, 16'h80A5, 16'hFF3C, 16'h1001};

  logic       clk = 1'b0;
  logic       arst_n;
  logic       bus_sel, bus_we;
  logic [1:0] bus_reg;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq;
  int         n_chk = 0, n_err = 0;
  logic [7:0] rv;
  logic       ie = 1'b0;

  always #2 clk = ~clk;

  nvm_write_ctrl #(.PROG_CYCLES(P), .UNLOCK_WINDOW(WIN)) uut (
    .clk(clk), .arst_n(arst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] r, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_reg = r; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] r, output logic [7:0] d);
    bus_reg = r;
    #1 d = bus_rdata;
  endtask

  // Control byte with done-flag write kept at 1 so it is not cleared.
  function automatic logic [7:0] cv(input logic wren, input logic go, input logic rdgo);
    return {3'b000, ie, 1'b1, wren, go, rdgo};
  endfunction

  task automatic arm_start(input logic [7:0] a, input logic [7:0] d, input int gap, input logic wren);
    wr(2'd0, a);
    wr(2'd1, d);
    wr(2'd2, cv(wren, 1'b0, 1'b0));
    wr(2'd3, 8'h55);
    wr(2'd3, 8'hAA);
    repeat (gap) @(negedge clk);
    wr(2'd2, cv(wren, 1'b1, 1'b0));
  endtask

  task automatic read_byte(input logic [7:0] a, output logic [7:0] d);
    wr(2'd0, a);
    wr(2'd2, cv(1'b0, 1'b0, 1'b1));
    rd(2'd1, d);
  endtask

  task automatic settle;
    repeat (P + 3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    bus_sel = 1'b0; bus_we = 1'b0; bus_reg = 2'd0; bus_wdata = 8'h00;
    arst_n = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), rv);
      check("R1 reg reset", rv, 8'h00);
    end
    check("R1 irq reset", {7'b0, irq}, 8'h00);

    // R3 table walk: guarded write then read back
    for (int i = 0; i < 4; i++) begin
      arm_start(VEC[i][15:8], VEC[i][7:0], 0, 1'b1);
      settle();
      read_byte(VEC[i][15:8], rv);
      check("R3 write then readback", rv, VEC[i][7:0]);
    end

    // R2 read bit reads 0; reading a second address
    rd(2'd2, rv);
    check("R2 read bit self clears", {7'b0, rv[0]}, 8'h00);
    read_byte(8'h03, rv);
    check("R2 read loads buffer", rv, 8'h12);

    // R4 busy span exact
    arm_start(8'h40, 8'h77, 0, 1'b1);
    rd(2'd2, rv);
    check("R4 busy on first cycle", {7'b0, rv[1]}, 8'h01);
    repeat (P - 1) @(negedge clk);
    rd(2'd2, rv);
    check("R4 busy on last cycle", {7'b0, rv[1]}, 8'h01);
    @(negedge clk);
    rd(2'd2, rv);
    check("R4 busy clears after PROG_CYCLES", {7'b0, rv[1]}, 8'h00);
    read_byte(8'h40, rv);
    check("R4 byte committed", rv, 8'h77);

    // R11 key reads zero, enable bits read back
    wr(2'd3, 8'h55);
    rd(2'd3, rv);
    check("R11 key reads zero", rv, 8'h00);
    repeat (WIN + 2) @(negedge clk);
    ie = 1'b1;
    wr(2'd2, cv(1'b1, 1'b0, 1'b0));
    rd(2'd2, rv);
    check("R11 wren and ie read back", {6'b0, rv[4], rv[2]}, 8'h03);
    ie = 1'b0;
    wr(2'd2, cv(1'b0, 1'b0, 1'b0));
    rd(2'd2, rv);
    check("R11 wren and ie cleared", {6'b0, rv[4], rv[2]}, 8'h00);

    // R5 start without unlock
    wr(2'd0, 8'h40); wr(2'd1, 8'h99);
    wr(2'd2, cv(1'b1, 1'b0, 1'b0));
    wr(2'd2, cv(1'b1, 1'b1, 1'b0));
    rd(2'd2, rv);
    check("R5 bare start not busy", {7'b0, rv[1]}, 8'h00);
    settle();
    read_byte(8'h40, rv);
    check("R5 array unchanged", rv, 8'h77);

    // R6 wrong second key, and repeated first key
    wr(2'd0, 8'h40); wr(2'd1, 8'h99);
    wr(2'd2, cv(1'b1, 1'b0, 1'b0));
    wr(2'd3, 8'h55); wr(2'd3, 8'h5A);
    wr(2'd2, cv(1'b1, 1'b1, 1'b0));
    rd(2'd2, rv);
    check("R6 wrong second key rejected", {7'b0, rv[1]}, 8'h00);
    wr(2'd3, 8'h55); wr(2'd3, 8'h55); wr(2'd3, 8'hAA);
    wr(2'd2, cv(1'b1, 1'b1, 1'b0));
    rd(2'd2, rv);
    check("R6 repeated first key rejected", {7'b0, rv[1]}, 8'h00);
    settle();
    read_byte(8'h40, rv);
    check("R6 array unchanged", rv, 8'h77);

    // R7 window edges: last allowed edge, then one late
    arm_start(8'h41, 8'h5E, WIN - 2, 1'b1);
    rd(2'd2, rv);
    check("R7 start on last window edge accepted", {7'b0, rv[1]}, 8'h01);
    settle();
    read_byte(8'h41, rv);
    check("R7 in-window byte stored", rv, 8'h5E);
    arm_start(8'h41, 8'hC3, WIN - 1, 1'b1);
    rd(2'd2, rv);
    check("R7 late start rejected", {7'b0, rv[1]}, 8'h00);
    settle();
    read_byte(8'h41, rv);
    check("R7 late start left array", rv, 8'h5E);

    // R8 permission bit clear
    arm_start(8'h41, 8'h0F, 0, 1'b0);
    rd(2'd2, rv);
    check("R8 no start without wren", {7'b0, rv[1]}, 8'h00);
    settle();
    read_byte(8'h41, rv);
    check("R8 array unchanged", rv, 8'h5E);

    // R9 flag and irq
    wr(2'd2, 8'h00);
    rd(2'd2, rv);
    check("R9 flag cleared by zero write", {7'b0, rv[3]}, 8'h00);
    wr(2'd2, 8'h08);
    rd(2'd2, rv);
    check("R9 writing one does not set flag", {7'b0, rv[3]}, 8'h00);
    arm_start(8'h50, 8'h2B, 0, 1'b1);
    settle();
    rd(2'd2, rv);
    check("R9 flag set on completion", {7'b0, rv[3]}, 8'h01);
    check("R9 irq low with ie clear", {7'b0, irq}, 8'h00);
    ie = 1'b1;
    wr(2'd2, cv(1'b0, 1'b0, 1'b0));
    #1 check("R9 irq high with ie set", {7'b0, irq}, 8'h01);
    wr(2'd2, 8'h10);
    #1 check("R9 irq drops when flag cleared", {7'b0, irq}, 8'h00);
    ie = 1'b0;
    wr(2'd2, 8'h00);

    // R10 register traffic during a write
    arm_start(8'h60, 8'hD4, 0, 1'b1);
    wr(2'd0, 8'h03);
    wr(2'd1, 8'hEE);
    wr(2'd2, cv(1'b1, 1'b0, 1'b1));
    rd(2'd1, rv);
    check("R10 read ignored while busy", rv, 8'hEE);
    settle();
    read_byte(8'h60, rv);
    check("R10 programmed from captured copies", rv, 8'hD4);
    read_byte(8'h03, rv);
    check("R10 other address untouched", rv, 8'h12);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule